// File: doc/BRIEF.md
# Sheep Move Guard

This block keeps track of a small board game played on an 8x8 grid. The squares are numbered 0 to 63, row by row, starting at the top-left corner. There are five pieces on the board: one sheep and a configurable number of wolves (four by default). A controller sends a move request for one piece. The request names the piece and one of the four diagonal directions. The block checks whether the requested square may be entered. If it may, the block moves the piece and returns a one-byte command code that a display or link partner can forward. If it may not, the block flags the request as refused and leaves every piece where it was.

Each request runs in a fixed sequence of two working cycles. In the first cycle the block works out the destination square and checks it against the board edges. In the second cycle it compares the destination with the squares held by the other pieces and applies the result. A restart request returns every piece to its starting square. The positions of all pieces are always visible on output ports. A separate flag is raised while the sheep stands on the goal square.

Top module: `sheep_move_guard`

## Requirements
- R1: After reset the sheep is on square 60 and wolf k (0-based) is on square 2k+1 (1, 3, 5, 7). At that point `ack_o`, `cmd_valid_o`, `illegal_o` and `win_o` are all low.
- R2: A request is taken on a rising edge where `req_i` is high, the block is idle and `ack_o` is low. `ack_o` then pulses high for exactly one cycle, becoming visible after the third rising edge counted from the accepting edge inclusive. A request seen while `ack_o` is high is ignored.
- R3: Direction code 0 (up-left) subtracts 9 from the square number. It is refused when the mover is on square 8, 24, 40 or 56. When the sheep makes this move the command byte is F1h.
- R4: Direction code 1 (up-right) subtracts 7. It is refused when the mover is on square 23, 39 or 55. When the sheep makes this move the command byte is F3h.
- R5: Direction code 2 (down-left) adds 7. It is refused when the mover is on a square numbered above 55, or on square 8, 24 or 40. When the sheep makes this move the command byte is F7h.
- R6: Direction code 3 (down-right) adds 9. It is refused when the mover is on a square numbered above 54, or on square 7, 23 or 39. When the sheep makes this move the command byte is F9h.
- R7: A move is refused when its destination is the square of any other piece.
- R8: A move whose destination falls outside 0..63 is refused.
- R9: A refused request gives `illegal_o` high together with `ack_o`, keeps `cmd_valid_o` low, and changes no position.
- R10: `win_o` is high exactly while the sheep is on square 1.
- R11: A request with `restart_i` high, whatever its piece and direction, puts every piece back on its starting square. It reports command byte 00h with `cmd_valid_o` high.
- R12: `piece_i` value 0 selects the sheep and value k+1 selects wolf k. Wolves may move only down-left or down-right. An accepted move by wolf k reports command byte {2'b00, k[1:0], 4'h7} for down-left or {2'b00, k[1:0], 4'h9} for down-right. A wolf asking to move upward, or a `piece_i` value above the number of wolves, is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Move or restart request, held until `ack_o` |
| restart_i | input | 1 | Request restores the starting placement |
| piece_i | input | IDX_W (3) | Piece selector: 0 = sheep, k+1 = wolf k |
| dir_i | input | 2 | 0 up-left, 1 up-right, 2 down-left, 3 down-right |
| ack_o | output | 1 | One-cycle completion pulse |
| cmd_valid_o | output | 1 | Accepted request; `cmd_o` holds its code |
| illegal_o | output | 1 | Refused request |
| cmd_o | output | 8 | Command byte of the last accepted request |
| win_o | output | 1 | Sheep is on the goal square |
| sheep_pos_o | output | POS_W (6) | Sheep square |
| wolf_pos_o | output | N_WOLVES*POS_W (24) | Wolf squares, wolf k in bits [6k+5:6k] |

## Verification
Some properties are checked on every cycle. The completion pulse never lasts longer than one cycle. A refusal never comes with a command and never moves a piece. Positions change only in a cycle that reports an accepted command. The sheep never shares a square with a wolf. Each sheep command code matches the actual step taken: the square moves by -9, -7, +7 or +9 according to F1h, F3h, F7h or F9h. A restart code always leaves the sheep on its home square. Other behaviour can only be shown by the bench's scenarios. This covers the exact three-cycle latency, the refusal of a request held through the acknowledge cycle, and each fixed edge list. It also covers off-board destinations from the top row, wolf-on-wolf collisions, wolf code values, and the goal flag being reached and then cleared by a restart.

// File: rtl/smg_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the sheep move guard.
// Assumes an 8x8 board; the per-direction step values depend on that width.
package smg_pkg;

    typedef enum logic [1:0] {
        DIR_UL = 2'd0,
        DIR_UR = 2'd1,
        DIR_DL = 2'd2,
        DIR_DR = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALC   = 2'd1,
        ST_COMMIT = 2'd2
    } state_e;

    localparam logic [7:0] CMD_RESTART = 8'h00;

    // Low nibble of a move code: the keypad digit matching the direction.
    function automatic logic [3:0] dir_nibble(input dir_e d);
        unique case (d)
            DIR_UL:  return 4'h1;
            DIR_UR:  return 4'h3;
            DIR_DL:  return 4'h7;
            default: return 4'h9;
        endcase
    endfunction

    // Full command byte: high nibble F for the sheep, {00, wolf index} for a wolf.
    function automatic logic [7:0] move_code(input logic is_sheep,
                                             input logic [1:0] wolf_idx,
                                             input dir_e d);
        return is_sheep ? {4'hF, dir_nibble(d)} : {2'b00, wolf_idx, dir_nibble(d)};
    endfunction

endpackage

// File: rtl/smg_target.sv
`timescale 1ns/1ps
// Module: smg_target
// Computes the destination square of a diagonal step and whether the step is
// barred by the fixed edge lists, by leaving the board, or by a wolf moving up.
// Assumes an 8x8 board (POS_W = 6); the edge lists are fixed square numbers.
module smg_target
    import smg_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic [POS_W-1:0] pos_i,
    input  dir_e             dir_i,
    input  logic             wolf_i,
    output logic [POS_W-1:0] target_o,
    output logic             blocked_o
);
    localparam int SUM_W = POS_W + 2;

    logic signed [SUM_W-1:0] step;
    logic signed [SUM_W-1:0] sum;
    logic                    edge_hit;
    logic                    off_board;
    int                      p;

    // Step selection, destination arithmetic and edge-list lookup.
    always_comb begin
        p = int'(pos_i);
        unique case (dir_i)
            DIR_UL: begin
                step     = SUM_W'(-9);
                edge_hit = (p == 8) || (p == 24) || (p == 40) || (p == 56);
            end
            DIR_UR: begin
                step     = SUM_W'(-7);
                edge_hit = (p == 23) || (p == 39) || (p == 55);
            end
            DIR_DL: begin
                step     = SUM_W'(7);
                edge_hit = (p > 55) || (p == 8) || (p == 24) || (p == 40);
            end
            default: begin
                step     = SUM_W'(9);
                edge_hit = (p > 54) || (p == 7) || (p == 23) || (p == 39);
            end
        endcase
        sum       = $signed({2'b00, pos_i}) + step;
        off_board = |sum[SUM_W-1:POS_W];
        target_o  = sum[POS_W-1:0];
        blocked_o = off_board | edge_hit |
                    (wolf_i & ((dir_i == DIR_UL) | (dir_i == DIR_UR)));
    end

endmodule

// File: rtl/smg_occupancy.sv
`timescale 1ns/1ps
// Module: smg_occupancy
// Flags a destination square already held by a piece other than the mover.
// Assumes the board vector holds piece i in slice [i*POS_W +: POS_W].
module smg_occupancy #(
    parameter int N_PIECES = 5,
    parameter int POS_W    = 6,
    parameter int IDX_W    = 3
) (
    input  logic [N_PIECES*POS_W-1:0] board_i,
    input  logic [IDX_W-1:0]          mover_i,
    input  logic [POS_W-1:0]          target_i,
    output logic                      hit_o
);
    logic [N_PIECES-1:0] match;

    for (genvar g = 0; g < N_PIECES; g++) begin : g_cmp
        // One comparator per piece, masked for the mover itself.
        assign match[g] = (board_i[g*POS_W +: POS_W] == target_i) &&
                          (mover_i != IDX_W'(g));
    end

    assign hit_o = |match;

endmodule

// File: rtl/smg_board.sv
`timescale 1ns/1ps
// Module: smg_board
// Position registers for the sheep (piece 0) and the wolves (pieces 1..N).
// Assumes the caller issues a move only for a legal, in-range mover.
module smg_board #(
    parameter int N_WOLVES   = 4,
    parameter int POS_W      = 6,
    parameter int SHEEP_HOME = 60,
    parameter int IDX_W      = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             restart_i,
    input  logic                             move_i,
    input  logic [IDX_W-1:0]                 mover_i,
    input  logic [POS_W-1:0]                 new_pos_i,
    output logic [(N_WOLVES+1)*POS_W-1:0]    board_o
);
    localparam int N_PIECES = N_WOLVES + 1;

    logic [POS_W-1:0] piece_q [N_PIECES];

    // Starting square of piece k: the sheep's home, or 2k-1 for wolves.
    function automatic logic [POS_W-1:0] home_sq(input int k);
        return (k == 0) ? POS_W'(SHEEP_HOME) : POS_W'(2 * k - 1);
    endfunction

    // Load starting squares on reset or restart, otherwise apply one move.
    always_ff @(posedge clk) begin
        for (int k = 0; k < N_PIECES; k++) begin
            if (!rst_n || restart_i) begin
                piece_q[k] <= home_sq(k);
            end else if (move_i && (mover_i == IDX_W'(k))) begin
                piece_q[k] <= new_pos_i;
            end
        end
    end

    for (genvar g = 0; g < N_PIECES; g++) begin : g_out
        assign board_o[g*POS_W +: POS_W] = piece_q[g];
    end

endmodule

// File: rtl/sheep_move_guard.sv
`timescale 1ns/1ps
// Module: sheep_move_guard (top)
// Accepts one move or restart request at a time, computes the destination in
// the first working cycle, checks occupancy and commits in the second, then
// pulses ack_o with either a command byte or a refusal.
// Assumes the requester holds req_i until ack_o and drops it right after.
module sheep_move_guard
    import smg_pkg::*;
#(
    parameter int N_WOLVES   = 4,
    parameter int POS_W      = 6,
    parameter int SHEEP_HOME = 60,
    parameter int WIN_SQ     = 1,
    localparam int N_PIECES  = N_WOLVES + 1,
    localparam int IDX_W     = $clog2(N_PIECES + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_i,
    input  logic                         restart_i,
    input  logic [IDX_W-1:0]             piece_i,
    input  logic [1:0]                   dir_i,
    output logic                         ack_o,
    output logic                         cmd_valid_o,
    output logic                         illegal_o,
    output logic [7:0]                   cmd_o,
    output logic                         win_o,
    output logic [POS_W-1:0]             sheep_pos_o,
    output logic [N_WOLVES*POS_W-1:0]    wolf_pos_o
);
    state_e                    state_q;
    logic [IDX_W-1:0]          piece_q;
    dir_e                      dir_q;
    logic                      restart_q;
    logic [POS_W-1:0]          tgt_q;
    logic                      blk_q;
    logic                      ack_q, valid_q, illegal_q;
    logic [7:0]                cmd_q;

    logic [N_PIECES*POS_W-1:0] board;
    logic [POS_W-1:0]          mover_pos;
    logic [POS_W-1:0]          tgt_next;
    logic                      tgt_blocked;
    logic                      piece_ok;
    logic                      hit;
    logic                      req_take;
    logic                      move_ok;
    logic                      do_restart;
    logic                      do_move;

    // Select the latched mover's current square from the board.
    always_comb begin
        mover_pos = '0;
        for (int k = 0; k < N_PIECES; k++) begin
            if (piece_q == IDX_W'(k)) mover_pos = board[k*POS_W +: POS_W];
        end
    end

    assign piece_ok   = piece_q < IDX_W'(N_PIECES);
    assign req_take   = (state_q == ST_IDLE) && req_i && !ack_q;
    assign move_ok    = !blk_q && !hit;
    assign do_restart = (state_q == ST_COMMIT) && restart_q;
    assign do_move    = (state_q == ST_COMMIT) && !restart_q && move_ok;

    smg_target #(.POS_W(POS_W)) u_target (
        .pos_i     (mover_pos),
        .dir_i     (dir_q),
        .wolf_i    (piece_q != '0),
        .target_o  (tgt_next),
        .blocked_o (tgt_blocked)
    );

    smg_occupancy #(.N_PIECES(N_PIECES), .POS_W(POS_W), .IDX_W(IDX_W)) u_occ (
        .board_i  (board),
        .mover_i  (piece_q),
        .target_i (tgt_q),
        .hit_o    (hit)
    );

    smg_board #(.N_WOLVES(N_WOLVES), .POS_W(POS_W),
                .SHEEP_HOME(SHEEP_HOME), .IDX_W(IDX_W)) u_board (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (do_restart),
        .move_i    (do_move),
        .mover_i   (piece_q),
        .new_pos_i (tgt_q),
        .board_o   (board)
    );

    // Request sequencer: latch, compute target, then compare and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            piece_q   <= '0;
            dir_q     <= DIR_UL;
            restart_q <= 1'b0;
            tgt_q     <= '0;
            blk_q     <= 1'b0;
            ack_q     <= 1'b0;
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            cmd_q     <= CMD_RESTART;
        end else begin
            ack_q     <= 1'b0;
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_take) begin
                        piece_q   <= piece_i;
                        dir_q     <= dir_e'(dir_i);
                        restart_q <= restart_i;
                        state_q   <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    tgt_q   <= tgt_next;
                    blk_q   <= tgt_blocked | ~piece_ok;
                    state_q <= ST_COMMIT;
                end
                ST_COMMIT: begin
                    ack_q <= 1'b1;
                    if (restart_q) begin
                        cmd_q   <= CMD_RESTART;
                        valid_q <= 1'b1;
                    end else if (move_ok) begin
                        cmd_q   <= move_code(piece_q == '0,
                                             2'(piece_q - IDX_W'(1)), dir_q);
                        valid_q <= 1'b1;
                    end else begin
                        illegal_q <= 1'b1;
                    end
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ack_o       = ack_q;
    assign cmd_valid_o = valid_q;
    assign illegal_o   = illegal_q;
    assign cmd_o       = cmd_q;
    assign sheep_pos_o = board[POS_W-1:0];
    assign wolf_pos_o  = board[N_PIECES*POS_W-1:POS_W];
    assign win_o       = sheep_pos_o == POS_W'(WIN_SQ);

endmodule

// File: rtl/smg_guard_checks.sv
`timescale 1ns/1ps
// Module: smg_guard_checks
// Cycle-level properties of the sheep move guard, attached by bind below.
// Assumes the same parameters as the bound top instance.
module smg_guard_checks #(
    parameter int N_WOLVES   = 4,
    parameter int POS_W      = 6,
    parameter int SHEEP_HOME = 60
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ack_o,
    input logic                      cmd_valid_o,
    input logic                      illegal_o,
    input logic [7:0]                cmd_o,
    input logic [POS_W-1:0]          sheep_pos_o,
    input logic [N_WOLVES*POS_W-1:0] wolf_pos_o
);
    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    a_r9_refusal_alone: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (ack_o && !cmd_valid_o));

    a_r9_refusal_keeps_board: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ($stable(sheep_pos_o) && $stable(wolf_pos_o)));

    a_r2_moves_only_when_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sheep_pos_o) || !$stable(wolf_pos_o)) |-> cmd_valid_o);

    a_r3_step_up_left: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == 8'hF1) |-> ($past(sheep_pos_o) == sheep_pos_o + POS_W'(9)));

    a_r4_step_up_right: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == 8'hF3) |-> ($past(sheep_pos_o) == sheep_pos_o + POS_W'(7)));

    a_r5_step_down_left: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == 8'hF7) |-> (sheep_pos_o == $past(sheep_pos_o) + POS_W'(7)));

    a_r6_step_down_right: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == 8'hF9) |-> (sheep_pos_o == $past(sheep_pos_o) + POS_W'(9)));

    a_r11_restart_home: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == 8'h00) |-> (sheep_pos_o == POS_W'(SHEEP_HOME)));

    for (genvar w = 0; w < N_WOLVES; w++) begin : g_sep
        a_r7_no_shared_square: assert property (@(posedge clk) disable iff (!rst_n)
            sheep_pos_o != wolf_pos_o[w*POS_W +: POS_W]);
    end

endmodule

bind sheep_move_guard smg_guard_checks #(
    .N_WOLVES   (N_WOLVES),
    .POS_W      (POS_W),
    .SHEEP_HOME (SHEEP_HOME)
) i_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_o       (ack_o),
    .cmd_valid_o (cmd_valid_o),
    .illegal_o   (illegal_o),
    .cmd_o       (cmd_o),
    .sheep_pos_o (sheep_pos_o),
    .wolf_pos_o  (wolf_pos_o)
);

// File: tb/test_sheep_move_guard.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results
// against hand-derived squares and command bytes.
module test_sheep_move_guard;

    localparam int NW = 4;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          restart = 1'b0;
    logic [2:0]    piece = '0;
    logic [1:0]    dir = '0;
    logic          ack, cmd_valid, illegal, win;
    logic [7:0]    cmd;
    logic [PW-1:0] sheep_pos;
    logic [NW*PW-1:0] wolf_pos;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_pos [NW+1];

    always #10 clk = ~clk;

    sheep_move_guard i_sheep_move_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .restart_i   (restart),
        .piece_i     (piece),
        .dir_i       (dir),
        .ack_o       (ack),
        .cmd_valid_o (cmd_valid),
        .illegal_o   (illegal),
        .cmd_o       (cmd),
        .win_o       (win),
        .sheep_pos_o (sheep_pos),
        .wolf_pos_o  (wolf_pos)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    task automatic set_home();
        exp_pos[0] = 60;
        for (int k = 1; k <= NW; k++) exp_pos[k] = 2 * k - 1;
    endtask

    task automatic check_board(input string tag);
        chk(int'(sheep_pos) == exp_pos[0], tag, "sheep square", int'(sheep_pos), exp_pos[0]);
        for (int k = 0; k < NW; k++)
            chk(int'(wolf_pos[k*PW +: PW]) == exp_pos[k+1], tag, "wolf square",
                int'(wolf_pos[k*PW +: PW]), exp_pos[k+1]);
    endtask

    // One request: checks latency, verdict, code and the whole board.
    task automatic issue(input bit rs, input int pc, input int dr, input bit ok,
                         input int exp_cmd, input int tgt, input string tag);
        int waited = 0;
        @(negedge clk);
        req = 1'b1; restart = rs; piece = 3'(pc); dir = 2'(dr);
        do begin
            @(negedge clk);
            waited++;
        end while (!ack && waited < 8);
        chk(waited == 3, tag, "ack latency", waited, 3);
        chk(cmd_valid == ok, tag, "cmd_valid", int'(cmd_valid), int'(ok));
        chk(illegal == !ok, tag, "illegal", int'(illegal), int'(!ok));
        if (ok) chk(int'(cmd) == exp_cmd, tag, "command byte", int'(cmd), exp_cmd);
        req = 1'b0; restart = 1'b0;
        if (ok && rs) set_home();
        else if (ok) exp_pos[pc] = tgt;
        check_board(tag);
    endtask

    task automatic t_reset();
        set_home();
        chk(!ack && !cmd_valid && !illegal, "R1", "flags after reset",
            {ack, cmd_valid, illegal}, 0);
        chk(!win, "R1", "win after reset", int'(win), 0);
        check_board("R1");
    endtask

    // Request held through the acknowledge cycle is not taken again.
    task automatic t_handshake();
        @(negedge clk);
        req = 1'b1; piece = 3'd0; dir = 2'd1;
        repeat (3) @(negedge clk);
        chk(ack, "R2", "ack after three edges", int'(ack), 1);
        chk(int'(cmd) == 'hF3, "R4", "up-right code", int'(cmd), 'hF3);
        @(negedge clk);
        req = 1'b0;
        chk(!ack, "R2", "ack single cycle", int'(ack), 0);
        repeat (4) @(negedge clk);
        chk(!ack, "R2", "held request ignored", int'(ack), 0);
        exp_pos[0] = 53;
        check_board("R2");
    endtask

    task automatic t_basic_steps();
        issue(0, 0, 0, 1, 'hF1, 44, "R3");
        issue(0, 0, 2, 1, 'hF7, 51, "R5");
        issue(0, 0, 3, 1, 'hF9, 60, "R6");
    endtask

    task automatic t_bottom_row();
        issue(0, 0, 2, 0, 0, 0, "R5");
        issue(0, 0, 3, 0, 0, 0, "R6");
    endtask

    task automatic t_left_edge();
        issue(1, 0, 0, 1, 'h00, 0, "R11");
        issue(0, 0, 0, 1, 'hF1, 51, "R3");
        issue(0, 0, 0, 1, 'hF1, 42, "R3");
        issue(0, 0, 0, 1, 'hF1, 33, "R3");
        issue(0, 0, 0, 1, 'hF1, 24, "R3");
        issue(0, 0, 0, 0, 0, 0, "R3");
        issue(0, 0, 2, 0, 0, 0, "R5");
    endtask

    task automatic t_right_edge();
        issue(1, 0, 0, 1, 'h00, 0, "R11");
        issue(0, 0, 1, 1, 'hF3, 53, "R4");
        issue(0, 0, 1, 1, 'hF3, 46, "R4");
        issue(0, 0, 1, 1, 'hF3, 39, "R4");
        issue(0, 0, 1, 0, 0, 0, "R4");
        issue(0, 0, 3, 0, 0, 0, "R6");
        issue(0, 0, 2, 1, 'hF7, 46, "R5");
    endtask

    task automatic t_wolf_block();
        issue(1, 0, 0, 1, 'h00, 0, "R11");
        for (int s = 0; s < 4; s++) issue(0, 0, 0, 1, 'hF1, 51 - 9 * s, "R3");
        issue(0, 0, 1, 1, 'hF3, 17, "R4");
        issue(0, 0, 1, 1, 'hF3, 10, "R4");
        issue(0, 0, 0, 0, 0, 0, "R7");
        issue(0, 0, 1, 0, 0, 0, "R7");
        chk(!win, "R10", "no win off goal", int'(win), 0);
    endtask

    task automatic t_wolves();
        issue(0, 2, 2, 0, 0, 0, "R7");
        issue(0, 1, 2, 1, 'h07, 8, "R12");
        issue(0, 2, 0, 0, 0, 0, "R12");
        issue(0, 5, 3, 0, 0, 0, "R12");
        issue(0, 4, 3, 0, 0, 0, "R12");
        issue(0, 4, 2, 1, 'h37, 14, "R12");
        issue(0, 3, 3, 0, 0, 0, "R7");
    endtask

    task automatic t_goal();
        issue(0, 0, 0, 1, 'hF1, 1, "R10");
        chk(win, "R10", "win on goal", int'(win), 1);
        issue(0, 0, 1, 0, 0, 0, "R8");
        issue(0, 0, 0, 0, 0, 0, "R8");
        issue(0, 0, 2, 0, 0, 0, "R7");
        chk(win, "R10", "win held", int'(win), 1);
        issue(1, 0, 3, 1, 'h00, 0, "R11");
        chk(!win, "R11", "win cleared by restart", int'(win), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_basic_steps();
        t_bottom_row();
        t_left_edge();
        t_right_edge();
        t_wolf_block();
        t_wolves();
        t_goal();
        report();
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

endmodule